// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a flat panel from packed configuration words written over a small write-only register port. Two counters, one for clocks within a line and one for lines within a frame, walk through the sync, back porch, active and front porch intervals. From their positions the block drives horizontal sync, vertical sync and data-enable, each with its own polarity. It also reports the pixel and line coordinates inside the active area and gives a one-cycle pulse at the start of each frame. One counter step is one pixel clock, and the `clk` input is taken to be that pixel clock.

Software writes a horizontal word, a vertical word, a polarity/clock word and a control word. Each field uses either a minus-one or a direct encoding, and the active width is given in units of 16 pixels. A written word is held in a live copy. The live copy moves into the working copy only at a frame boundary, or at once while the generator is stopped, so a frame never mixes two configurations. In split-screen (dual) mode the line field gives half the panel height. Both halves are scanned together, and a second line coordinate names the matching line in the lower half.

The block has no streaming interface. Its write port and all of its outputs are plain control pins with no back-pressure, and a write is taken on any clock where `wr_en` is high.

Top module: `lcd_raster_gen`

## Requirements
- R1: Word 0 (`wr_addr`=0) sets the horizontal timing. Bits 7:2 hold active pixels/16 − 1, bits 15:8 hold sync width − 1, bits 23:16 hold front porch − 1 and bits 31:24 hold back porch − 1. Each line runs sync, then back porch, then active, then front porch. `hsync_o` is asserted for the sync clocks, and the line lasts the sum of the four intervals.
- R2: Word 1 sets the vertical timing. Bits 9:0 hold active lines − 1 and bits 15:10 hold vsync width − 1. Bits 23:16 hold the front porch and bits 31:24 the back porch, both as direct line counts. The line counter advances at the end of each line, and a frame runs vsync, back porch, active, front porch, with `vsync_o` asserted for whole sync lines.
- R3: In word 2, bit 11 inverts vsync, bit 12 inverts hsync, bit 14 inverts data-enable and bit 13 drives `pclk_inv_o`. A clear bit means the signal is active high.
- R4: Data-enable is asserted only when both counters are in their active windows. There `pix_x_o` runs 0..width−1 and `line_y_o` runs 0..lines−1, and both read 0 everywhere else.
- R5: Word 3 bit 7 selects dual mode. The frame still has (line field + 1) active lines, and `line_y2_o` equals `line_y_o` + (line field + 1) in the active area. In single mode `line_y2_o` stays 0.
- R6: Word 3 bit 0 enables the generator. While it is off, the counters rest at zero, hsync, vsync and data-enable sit at their inactive levels, and `frame_start_o` stays low. `panel_pwr_o` is word 3 bit 11 ANDed with the enable.
- R7: While the generator runs, writes do not affect the outputs until the next frame boundary.
- R8: `frame_start_o` is a one-cycle pulse on the first clock of the vsync interval.
- R9: `clk_sel_o` follows word 2 bit 5 and `div_bypass_o` follows word 2 bit 26, both updating at the same time as the other settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word select 0..3 |
| wr_data | input | 32 | Write data |
| hsync_o | output | 1 | Horizontal sync, polarity per word 2 |
| vsync_o | output | 1 | Vertical sync, polarity per word 2 |
| de_o | output | 1 | Data-enable, polarity per word 2 |
| pclk_inv_o | output | 1 | Pixel clock edge invert |
| clk_sel_o | output | 1 | Clock source select |
| div_bypass_o | output | 1 | Clock divider bypass |
| panel_pwr_o | output | 1 | Panel power enable |
| frame_start_o | output | 1 | First clock of a frame |
| pix_x_o | output | 12 | Active pixel coordinate |
| line_y_o | output | 12 | Active line coordinate |
| line_y2_o | output | 12 | Lower-half line coordinate in dual mode |

## Verification
The bench changes the horizontal word in the middle of a frame and checks that the rest of that frame keeps the old width. A design that applied writes at once would show a torn line with a larger `pix_x_o`. Full frames are compared against a cycle-indexed model with one porch encoded minus-one and the other direct, so an off-by-one in either encoding shifts `vsync_o` or the active window and is caught. Inverted polarities are checked both while running and while stopped, which catches a design that parks its outputs at logic 0 instead of at the inactive level. Dual mode is run to confirm the frame height does not double and that the second coordinate is offset by exactly the half height.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int CNT_W = 12;

  // Raw fields as held in the configuration words
  typedef struct packed {
    logic [5:0] ppl_m1;
    logic [7:0] hsw_m1;
    logic [7:0] hfp_m1;
    logic [7:0] hbp_m1;
    logic [9:0] lines_m1;
    logic [5:0] vsw_m1;
    logic [7:0] vfp;
    logic [7:0] vbp;
    logic       inv_v;
    logic       inv_h;
    logic       inv_pclk;
    logic       inv_de;
    logic       clk_sel;
    logic       div_bypass;
    logic       en;
    logic       pwr;
    logic       dual;
  } lcdt_cfg_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  output lcdt_cfg_t         cfg_o
);
  localparam logic [ADDR_W-1:0] A_HOR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VER = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(3);

  lcdt_cfg_t live_q, work_q;
  logic      load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_HOR: begin
          live_q.ppl_m1 <= wr_data[7:2];
          live_q.hsw_m1 <= wr_data[15:8];
          live_q.hfp_m1 <= wr_data[23:16];
          live_q.hbp_m1 <= wr_data[31:24];
        end
        A_VER: begin
          live_q.lines_m1 <= wr_data[9:0];
          live_q.vsw_m1   <= wr_data[15:10];
          live_q.vfp      <= wr_data[23:16];
          live_q.vbp      <= wr_data[31:24];
        end
        A_POL: begin
          live_q.clk_sel    <= wr_data[5];
          live_q.inv_v      <= wr_data[11];
          live_q.inv_h      <= wr_data[12];
          live_q.inv_pclk   <= wr_data[13];
          live_q.inv_de     <= wr_data[14];
          live_q.div_bypass <= wr_data[26];
        end
        A_CTL: begin
          live_q.en   <= wr_data[0];
          live_q.dual <= wr_data[7];
          live_q.pwr  <= wr_data[11];
        end
        default: ;
      endcase
    end
  end

  // Working copy follows freely while stopped, else only at a frame edge
  assign load = !work_q.en || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n)    work_q <= '0;
    else if (load) work_q <= live_q;
  end

  assign cfg_o = work_q;

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (work_q.en && !frame_end) |=> $stable(work_q)); // R7
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] sync_len,
  input  logic [W-1:0] back_len,
  input  logic [W-1:0] act_len,
  input  logic [W-1:0] front_len,
  output logic         in_sync,
  output logic         in_act,
  output logic         first,
  output logic         last,
  output logic [W-1:0] pos
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_beg, act_end, total;

  assign act_beg = sync_len + back_len;
  assign act_end = act_beg + act_len;
  assign total   = act_end + front_len;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step)       cnt_q <= last ? '0 : cnt_q + W'(1);
  end

  assign in_sync = cnt_q < sync_len;
  assign in_act  = (cnt_q >= act_beg) && (cnt_q < act_end);
  assign first   = cnt_q == '0;
  assign last    = cnt_q == total - W'(1);
  assign pos     = in_act ? cnt_q - act_beg : '0;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < total); // R1
  AST_SYNC_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_act |-> !in_sync); // R2
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = lcdt_pkg::CNT_W,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_inv_o,
  output logic              clk_sel_o,
  output logic              div_bypass_o,
  output logic              panel_pwr_o,
  output logic              frame_start_o,
  output logic [CNT_W-1:0]  pix_x_o,
  output logic [CNT_W-1:0]  line_y_o,
  output logic [CNT_W-1:0]  line_y2_o
);
  localparam int PPL_SHIFT = 4;

  lcdt_cfg_t  cfg;
  logic       run, frame_end;
  logic       h_sync, h_act, h_first, h_last;
  logic       v_sync, v_act, v_first, v_last;
  logic [CNT_W-1:0] h_pos, v_pos;
  logic [CNT_W-1:0] hsw, hbp, ppl, hfp, vsw, vbp, lines, vfp;
  logic       area;

  // Field expansion: minus-one fields get +1, vertical porches are direct
  assign ppl   = (CNT_W'(cfg.ppl_m1) + CNT_W'(1)) << PPL_SHIFT;
  assign hsw   = CNT_W'(cfg.hsw_m1) + CNT_W'(1);
  assign hfp   = CNT_W'(cfg.hfp_m1) + CNT_W'(1);
  assign hbp   = CNT_W'(cfg.hbp_m1) + CNT_W'(1);
  assign lines = CNT_W'(cfg.lines_m1) + CNT_W'(1);
  assign vsw   = CNT_W'(cfg.vsw_m1) + CNT_W'(1);
  assign vfp   = CNT_W'(cfg.vfp);
  assign vbp   = CNT_W'(cfg.vbp);

  assign run       = cfg.en;
  assign frame_end = run && h_last && v_last;

  lcdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_end(frame_end), .cfg_o(cfg)
  );

  lcdt_axis #(.W(CNT_W)) hax_i (
    .clk(clk), .rst_n(rst_n), .clear(!run), .step(run),
    .sync_len(hsw), .back_len(hbp), .act_len(ppl), .front_len(hfp),
    .in_sync(h_sync), .in_act(h_act), .first(h_first), .last(h_last),
    .pos(h_pos)
  );

  lcdt_axis #(.W(CNT_W)) vax_i (
    .clk(clk), .rst_n(rst_n), .clear(!run), .step(run && h_last),
    .sync_len(vsw), .back_len(vbp), .act_len(lines), .front_len(vfp),
    .in_sync(v_sync), .in_act(v_act), .first(v_first), .last(v_last),
    .pos(v_pos)
  );

  assign area = run && h_act && v_act;

  assign hsync_o       = (run && h_sync) ^ cfg.inv_h;
  assign vsync_o       = (run && v_sync) ^ cfg.inv_v;
  assign de_o          = area ^ cfg.inv_de;
  assign frame_start_o = run && h_first && v_first;
  assign pix_x_o       = area ? h_pos : '0;
  assign line_y_o      = area ? v_pos : '0;
  assign line_y2_o     = (area && cfg.dual) ? v_pos + lines : '0;
  assign panel_pwr_o   = run && cfg.pwr;
  assign pclk_inv_o    = cfg.inv_pclk;
  assign clk_sel_o     = cfg.clk_sel;
  assign div_bypass_o  = cfg.div_bypass;

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R8
  AST_FS_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (vsync_o != cfg.inv_v)); // R8
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (h_first && v_first)); // R6
  AST_X_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    area |-> (h_pos < ppl)); // R4
  AST_Y_IN_HEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    area |-> (v_pos < lines)); // R5
endmodule

// File: tb/lcd_raster_gen_tb_top.sv
module lcd_raster_gen_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hsync_o, vsync_o, de_o, pclk_inv_o, clk_sel_o, div_bypass_o;
  logic        panel_pwr_o, frame_start_o;
  logic [W-1:0] pix_x_o, line_y_o, line_y2_o;

  int n_checks = 0;
  int n_fail   = 0;

  lcd_raster_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pclk_inv_o(pclk_inv_o), .clk_sel_o(clk_sel_o),
    .div_bypass_o(div_bypass_o), .panel_pwr_o(panel_pwr_o),
    .frame_start_o(frame_start_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o),
    .line_y2_o(line_y2_o)
  );

  // Config A: 16 px, hsync 6, hbp 7, hfp 8; 4 lines, vsync 2, vbp 1, vfp 2
  localparam logic [31:0] HOR_A = (32'd0 << 2) | (32'd5 << 8) | (32'd7 << 16) | (32'd6 << 24);
  localparam logic [31:0] VER_A = 32'd3 | (32'd1 << 10) | (32'd2 << 16) | (32'd1 << 24);
  // Config B: 32 px, hsync 8, hbp 6, hfp 6
  localparam logic [31:0] HOR_B = (32'd1 << 2) | (32'd7 << 8) | (32'd5 << 16) | (32'd5 << 24);
  localparam logic [31:0] POL_INV = (32'd1 << 11) | (32'd1 << 12) | (32'd1 << 13) | (32'd1 << 14);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fs(input int limit, input string req);
    int n = 0;
    while (!frame_start_o && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(frame_start_o == 1'b1, req, "frame start seen", int'(frame_start_o), 1);
  endtask

  // Compare a whole frame, plus the next frame's first clock, to a model
  task automatic check_frame(input string tag, input int hsw, hbp, ppl, hfp,
                             input int vsw, vbp, lines, vfp,
                             input bit ih, iv, ide, dual);
    int htot, vtot, tot;
    int bad[7], fa[7], fe[7];
    string nm[7];
    string rq[7];
    nm = '{"hsync", "vsync", "de", "pix_x", "line_y", "line_y2", "frame_start"};
    rq = '{"R1", "R2", "R4", "R4", "R4", "R5", "R8"};
    htot = hsw + hbp + ppl + hfp;
    vtot = vsw + vbp + lines + vfp;
    tot  = htot * vtot;
    for (int k = 0; k < 7; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
    wait_fs(3 * tot + 100, "R8");
    for (int idx = 0; idx <= tot; idx++) begin
      int h, v, ex, ey, act_v[7], exp_v[7];
      bit ha, va;
      h  = idx % htot;
      v  = (idx / htot) % vtot;
      ha = (h >= hsw + hbp) && (h < hsw + hbp + ppl);
      va = (v >= vsw + vbp) && (v < vsw + vbp + lines);
      ex = (ha && va) ? h - hsw - hbp : 0;
      ey = (ha && va) ? v - vsw - vbp : 0;
      exp_v[0] = int'((h < hsw) ^ ih);
      exp_v[1] = int'((v < vsw) ^ iv);
      exp_v[2] = int'((ha && va) ^ ide);
      exp_v[3] = ex;
      exp_v[4] = ey;
      exp_v[5] = (dual && ha && va) ? ey + lines : 0;
      exp_v[6] = (idx == 0 || idx == tot) ? 1 : 0;
      act_v[0] = int'(hsync_o);
      act_v[1] = int'(vsync_o);
      act_v[2] = int'(de_o);
      act_v[3] = int'(pix_x_o);
      act_v[4] = int'(line_y_o);
      act_v[5] = int'(line_y2_o);
      act_v[6] = int'(frame_start_o);
      for (int k = 0; k < 7; k++) begin
        if (act_v[k] != exp_v[k] && bad[k] == 0) begin
          fa[k] = act_v[k]; fe[k] = exp_v[k];
        end
        if (act_v[k] != exp_v[k]) bad[k]++;
      end
      if (idx < tot) @(negedge clk);
    end
    for (int k = 0; k < 7; k++)
      chk(bad[k] == 0, rq[k], {tag, " ", nm[k], " first mismatch"}, fa[k], fe[k]);
  endtask

  task automatic t_reset;
    chk(hsync_o == 1'b0, "R6", "reset hsync", int'(hsync_o), 0);
    chk(vsync_o == 1'b0, "R6", "reset vsync", int'(vsync_o), 0);
    chk(de_o == 1'b0, "R6", "reset de", int'(de_o), 0);
    chk(frame_start_o == 1'b0, "R6", "reset frame_start", int'(frame_start_o), 0);
    chk(panel_pwr_o == 1'b0, "R6", "reset power", int'(panel_pwr_o), 0);
  endtask

  task automatic t_single;  // R1 R2 R4 R5 R8 with config A
    wr(0, HOR_A);
    wr(1, VER_A);
    wr(3, 32'h1 | (32'h1 << 11));
    check_frame("single A", 6, 7, 16, 8, 2, 1, 4, 2, 0, 0, 0, 0);
    chk(panel_pwr_o == 1'b1, "R6", "power on", int'(panel_pwr_o), 1);
  endtask

  task automatic t_boundary;  // R7: mid-frame width change waits for boundary
    int maxx = 0;
    wr(0, HOR_B);
    while (!frame_start_o) begin
      if (int'(pix_x_o) > maxx) maxx = int'(pix_x_o);
      @(negedge clk);
    end
    chk(maxx == 15, "R7", "old width kept to frame end", maxx, 15);
    check_frame("single B", 8, 6, 32, 6, 2, 1, 4, 2, 0, 0, 0, 0);
  endtask

  task automatic t_polarity;  // R3 R7
    wr(2, POL_INV);
    chk(pclk_inv_o == 1'b0, "R7", "pclk invert deferred", int'(pclk_inv_o), 0);
    check_frame("inverted B", 8, 6, 32, 6, 2, 1, 4, 2, 1, 1, 1, 0);
    chk(pclk_inv_o == 1'b1, "R3", "pclk invert applied", int'(pclk_inv_o), 1);
  endtask

  task automatic t_dual;  // R5
    wr(3, 32'h1 | (32'h1 << 7) | (32'h1 << 11));
    check_frame("dual B", 8, 6, 32, 6, 2, 1, 4, 2, 1, 1, 1, 1);
  endtask

  task automatic t_disable;  // R6 R7
    int n = 0;
    int bh = 0, bv = 0, bd = 0, bf = 0, bx = 0;
    wr(3, 32'h0);
    chk(panel_pwr_o == 1'b1, "R7", "power held until boundary", int'(panel_pwr_o), 1);
    while (panel_pwr_o && n < 2000) begin @(negedge clk); n++; end
    chk(panel_pwr_o == 1'b0, "R6", "power off after boundary", int'(panel_pwr_o), 0);
    for (int i = 0; i < 60; i++) begin
      if (hsync_o != 1'b1) bh++;
      if (vsync_o != 1'b1) bv++;
      if (de_o != 1'b1) bd++;
      if (frame_start_o != 1'b0) bf++;
      if (pix_x_o != '0) bx++;
      @(negedge clk);
    end
    chk(bh == 0, "R6", "stopped hsync inactive high", bh, 0);
    chk(bv == 0, "R6", "stopped vsync inactive high", bv, 0);
    chk(bd == 0, "R6", "stopped de inactive high", bd, 0);
    chk(bf == 0, "R6", "stopped no frame start", bf, 0);
    chk(bx == 0, "R6", "stopped pix_x zero", bx, 0);
  endtask

  task automatic t_clock_bits;  // R9 R3
    wr(2, (32'h1 << 5) | (32'h1 << 26));
    @(negedge clk);
    chk(clk_sel_o == 1'b1, "R9", "clock select", int'(clk_sel_o), 1);
    chk(div_bypass_o == 1'b1, "R9", "divider bypass", int'(div_bypass_o), 1);
    chk(hsync_o == 1'b0, "R3", "hsync inactive low after invert cleared", int'(hsync_o), 0);
    chk(pclk_inv_o == 1'b0, "R3", "pclk invert cleared", int'(pclk_inv_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-R: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_boundary();
    t_polarity();
    t_dual();
    t_disable();
    t_clock_bits();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule